// File: doc/BRIEF.md
# Boolean Network Damage-Spreading Meter

This block holds one synchronous random Boolean network and runs two copies of it in lockstep. Both copies share the same wiring and lookup tables; only their state registers differ. A run starts from a loaded initial state vector. The reference copy starts from that vector unchanged, while the twin copy starts from the same vector with one chosen node's bit inverted. Both copies then advance a programmed number of synchronous updates. The block then reports how many node bits differ between them, which is the spread of that single-bit fault.

Software, or a surrounding controller, first writes the network. Each node receives FANIN source indices and a 2^FANIN-entry truth table. The controller then loads an initial state, picks a node to perturb and a step count, and pulses start. The block answers with a one-cycle done pulse and holds the damage count on its output.

Top module: `bn_damage_meter`

## Requirements
- R1: After reset, busy, done and damage are all 0.
- R2: A write with cfg_we high and busy low stores the node's sources and table. Source j is the field cfg_src[j*IDXW +: IDXW]. Bit j of the table address is the current state of source j. The node's next state is cfg_lut at that address.
- R3: All nodes of a copy update at once, each from the state vector of the previous step.
- R4: When a run starts, the twin copy holds the loaded state with only bit perturb_idx inverted, and the reference copy holds the loaded state unchanged.
- R5: damage equals the number of bit positions in which the two copies differ after exactly step_count updates.
- R6: A step_count of 0 reports a damage of 1.
- R7: done is high for exactly one cycle. It rises on the clock edge that comes step_count+2 edges after the edge that samples start. busy falls on that same edge, and damage holds its value until the next run ends.
- R8: A start pulse while busy is high has no effect on the running measurement, its timing or its result.
- R9: While busy is high, writes on cfg_we and load_we are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one node's configuration |
| cfg_node | input | IDXW | Node being configured |
| cfg_src | input | FANIN*IDXW | Packed source indices, source j at bits j*IDXW |
| cfg_lut | input | 2^FANIN | Truth table, bit a is the output for address a |
| load_we | input | 1 | Write strobe for the initial state vector |
| load_state | input | NODES | Initial state, bit i for node i |
| perturb_idx | input | IDXW | Node whose bit is inverted in the twin copy |
| step_count | input | STEPW | Number of synchronous updates per run |
| start | input | 1 | Begins a run when busy is low |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when damage is valid |
| damage | output | IDXW+1 | Hamming distance between the two copies |

## Verification
The assertions assume that start is only acted on while the block is idle. They also assume that the network is fully written before the first run, so that no copy reads an unwritten table. The stimulus writes every node's sources and table and loads a state before each sweep. It never generates a source index equal to the node's own index. It issues the extra start pulse, and the configuration and load writes meant to be ignored, only inside a run whose start cycle and step count are known to the bench.

// File: rtl/bn_damage_meter.sv
module bn_damage_meter #(
  parameter int NODES = 64,
  parameter int FANIN = 2,
  parameter int STEPW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NODES)-1:0] cfg_node,
  input  logic [FANIN*$clog2(NODES)-1:0] cfg_src,
  input  logic [(1<<FANIN)-1:0]    cfg_lut,
  input  logic                     load_we,
  input  logic [NODES-1:0]         load_state,
  input  logic [$clog2(NODES)-1:0] perturb_idx,
  input  logic [STEPW-1:0]         step_count,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic [$clog2(NODES):0]   damage
);
  localparam int IDXW = $clog2(NODES);
  localparam int LUTW = 1 << FANIN;

  typedef enum logic [1:0] {IDLE, RUN, TALLY} phase_t;

  phase_t                  phase;
  logic [FANIN*IDXW-1:0]   src_q  [NODES];
  logic [LUTW-1:0]         lut_q  [NODES];
  logic [NODES-1:0]        init_q, ref_q, twin_q, ref_nx, twin_nx;
  logic [STEPW-1:0]        left_q;
  logic [IDXW:0]           diff_cnt;

  assign busy = (phase != IDLE);

  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      logic [FANIN-1:0] ra, ta;
      for (int j = 0; j < FANIN; j++) begin
        ra[j] = ref_q[src_q[i][j*IDXW +: IDXW]];
        ta[j] = twin_q[src_q[i][j*IDXW +: IDXW]];
      end
      ref_nx[i]  = lut_q[i][ra];
      twin_nx[i] = lut_q[i][ta];
    end
  end

  always_comb begin
    diff_cnt = '0;
    for (int i = 0; i < NODES; i++)
      diff_cnt = diff_cnt + (IDXW+1)'(ref_q[i] ^ twin_q[i]);
  end

  always_ff @(posedge clk) begin
    if (cfg_we && !busy) begin
      src_q[cfg_node] <= cfg_src;
      lut_q[cfg_node] <= cfg_lut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= IDLE;
      done   <= 1'b0;
      damage <= '0;
      init_q <= '0;
      ref_q  <= '0;
      twin_q <= '0;
      left_q <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: begin
          if (load_we) init_q <= load_state;
          if (start) begin
            ref_q  <= init_q;
            twin_q <= init_q ^ (NODES'(1) << perturb_idx);
            left_q <= step_count;
            phase  <= RUN;
          end
        end
        RUN: begin
          if (left_q == '0) phase <= TALLY;
          else begin
            ref_q  <= ref_nx;
            twin_q <= twin_nx;
            left_q <= left_q - 1'b1;
          end
        end
        TALLY: begin
          damage <= diff_cnt;
          done   <= 1'b1;
          phase  <= IDLE;
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bn_damage_meter_chk.sv
module bn_damage_meter_chk #(
  parameter int NODES = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [$clog2(NODES):0] damage
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_start_launches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_damage_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    damage <= ($clog2(NODES)+1)'(NODES));
  assert_damage_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && busy) |-> $stable(damage));
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && damage == '0));
endmodule

bind bn_damage_meter bn_damage_meter_chk #(.NODES(NODES)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .damage(damage));

// File: tb/bn_damage_meter_tb_top.sv
`timescale 1ns/1ps
module bn_damage_meter_tb_top;
  localparam int NODES = 64;
  localparam int FANIN = 2;
  localparam int STEPW = 16;
  localparam int IDXW  = $clog2(NODES);
  localparam int LUTW  = 1 << FANIN;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, load_we = 0, start = 0;
  logic [IDXW-1:0] cfg_node = '0, perturb_idx = '0;
  logic [FANIN*IDXW-1:0] cfg_src = '0;
  logic [LUTW-1:0] cfg_lut = '0;
  logic [NODES-1:0] load_state = '0;
  logic [STEPW-1:0] step_count = '0;
  logic busy, done;
  logic [IDXW:0] damage;

  int checks = 0, failures = 0;
  int m_src [NODES][FANIN];
  logic [LUTW-1:0] m_lut [NODES];
  logic [NODES-1:0] m_init;

  always #4 clk = ~clk;

  bn_damage_meter #(.NODES(NODES), .FANIN(FANIN), .STEPW(STEPW)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NODES-1:0] m_step(input logic [NODES-1:0] s);
    logic [NODES-1:0] r;
    for (int i = 0; i < NODES; i++) begin
      int a = 0;
      for (int j = 0; j < FANIN; j++) a += int'(s[m_src[i][j]]) << j;
      r[i] = m_lut[i][a];
    end
    return r;
  endfunction

  function automatic int m_damage(input int p, input int steps);
    logic [NODES-1:0] a = m_init, b = m_init;
    int c = 0;
    b[p] = ~b[p];
    for (int k = 0; k < steps; k++) begin a = m_step(a); b = m_step(b); end
    for (int i = 0; i < NODES; i++) c += int'(a[i] ^ b[i]);
    return c;
  endfunction

  task automatic write_net();
    for (int i = 0; i < NODES; i++) begin
      for (int j = 0; j < FANIN; j++) begin
        int s = $urandom_range(NODES-1);
        if (s == i) s = (s + 1) % NODES;
        m_src[i][j] = s;
        cfg_src[j*IDXW +: IDXW] = IDXW'(s);
      end
      m_lut[i] = LUTW'($urandom);
      cfg_lut = m_lut[i];
      cfg_node = IDXW'(i);
      cfg_we = 1;
      @(negedge clk);
    end
    cfg_we = 0;
  endtask

  task automatic load(input logic [NODES-1:0] v);
    m_init = v;
    load_state = v;
    load_we = 1;
    @(negedge clk);
    load_we = 0;
  endtask

  // meddle: 1 = extra start mid-run (R8), 2 = config/load writes mid-run (R9)
  task automatic run(input int p, input int steps, input int meddle);
    int c = 0;
    int exp = m_damage(p, steps);
    perturb_idx = IDXW'(p);
    step_count = STEPW'(steps);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && c < 1000) begin
      if (c == 1 && meddle == 1) begin
        start = 1; perturb_idx = IDXW'((p + 5) % NODES); step_count = '0;
      end else if (c == 1 && meddle == 2) begin
        load_we = 1; load_state = ~m_init;
        cfg_we = 1; cfg_node = IDXW'(p); cfg_lut = ~m_lut[p];
      end else begin
        start = 0; load_we = 0; cfg_we = 0;
      end
      @(negedge clk);
      c++;
    end
    start = 0; load_we = 0; cfg_we = 0;
    if (c >= 1000) check("watchdog R7", c, steps + 2);
    if (meddle == 1)      check("R8 timing", c, steps + 2);
    else if (meddle == 2) check("R9 timing", c, steps + 2);
    else                  check("R7 done latency", c, steps + 2);
    if (steps == 0)       check("R6 zero steps", int'(damage), 1);
    else if (meddle == 1) check("R8 damage", int'(damage), exp);
    else if (meddle == 2) check("R9 damage", int'(damage), exp);
    else                  check("R5 R3 R4 R2 damage", int'(damage), exp);
    check("R7 busy low at done", int'(busy), 0);
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    check("R7 damage held", int'(damage), exp);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 damage", int'(damage), 0);
    rst_n = 1;
    @(negedge clk);
    for (int t = 0; t < 4; t++) begin
      write_net();
      load({$urandom, $urandom});
      for (int p = 0; p < NODES; p++) run(p, (p * 7 + t * 3) % 23, 0);
      run(t * 9, 0, 0);
      run(t * 11 + 3, 12, 1);
      run(t * 13 + 1, 9, 2);
      run(t * 13 + 1, 9, 0);
    end
    m_init = '0;
    write_net();
    load('0);
    run(0, 0, 0);
    run(NODES - 1, 30, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule